// File: doc/BRIEF.md
# Dual-Line Interrupt and Event Controller

This block collects one-cycle event pulses from the sources of a measurement peripheral into two banks of sticky status bits. Each bank has its own mask register and its own active-low interrupt request line. Software finds the cause of a request by reading a status register. It acknowledges the event by writing ones to the bits it has handled. A few bits of the first bank are nonmaskable, and a configuration bit can also fold the first request line onto the second.

A second output is not latched. It follows up to sixteen live level signals, each gated by an event-mask bit. A duration measured on that output matches the duration of the underlying condition. A two-bit pin-function field picks whether this event output or one of two alternative functions reaches a shared pin. All registers sit behind a simple single-cycle write port and a registered read port.

Top module: `irq_event_ctrl`

## Requirements
- R1: The two request lines `irq0_n` and `irq1_n` are active low and independent. An enabled event in bank 1 drives `irq1_n` low and leaves `irq0_n` high.
- R2: A pulse on a bit of `src_pulse0` or `src_pulse1` sets the matching bit of status 0 (address 0) or status 1 (address 1). It sets the bit whatever the mask, and the bit stays set until it is acknowledged.
- R3: A request line is low while any status bit is set whose bit in the same bank's mask is 1. Mask 0 is at address 2 and mask 1 at address 3. A set status bit with mask bit 0 leaves the line high.
- R4: Writing a status address clears the bits written as 1 and leaves the bits written as 0 unchanged. The line stays low until every enabled bit has been cleared, then returns high.
- R5: Status 0 bit 16 (reset done) and bit 18 (error) are nonmaskable: they drive `irq0_n` low with their mask bit at 0.
- R6: With the combine bit set (configuration address 5, bit 0), `irq1_n` is low for enabled events of either bank, and `irq0_n` still shows only bank 0.
- R7: `evt_n` is low while any `evt_level` input whose event-mask bit is 1 is high. It goes high once all enabled inputs are low. The inputs are not latched.
- R8: The event mask (address 4, bits 15:0) is all zero after reset, so no level input affects `evt_n`.
- R9: `pin_out` carries `evt_n` when configuration bits 2:1 equal 2'b10. It carries `pin_alt_b` for 2'b01 and `pin_alt_a` for 2'b00 and 2'b11.
- R10: A source pulse and an acknowledge write hitting the same status bit in the same cycle leave the bit set.
- R11: Reset clears all masks, status 1 and the configuration, loads status 0 with only the reset-done bit, and holds `irq0_n`, `irq1_n`, `evt_n` and `pin_out` high.
- R12: All four outputs are registered. A source pulse changes its request line two clock edges after the pulse, and a level change reaches `evt_n` and `pin_out` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| src_pulse0 | input | 32 | Event pulses for status bank 0 |
| src_pulse1 | input | 32 | Event pulses for status bank 1 |
| evt_level | input | 16 | Live level signals for the event output |
| pin_alt_a | input | 1 | Alternative function A for the shared pin |
| pin_alt_b | input | 1 | Alternative function B for the shared pin |
| irq0_n | output | 1 | Request line 0, active low |
| irq1_n | output | 1 | Request line 1, active low |
| evt_n | output | 1 | Unlatched event output, active low |
| pin_out | output | 1 | Shared pin after function selection |

## Verification
The event output is driven from a table of mask, level and pin-function combinations. The table covers: all inputs high with nothing enabled, a single enabled source following its level, two enabled sources where one alone holds the output low, and every pin-function code with the alternative inputs at opposite levels so that a wrong selection shows. The request lines are tried with masked and unmasked pulses and with two pending bits acknowledged one at a time, which separates clearing one bit from clearing all. Further patterns exercise the nonmaskable bits with their mask at zero, the combine bit switched on and off while a bank-0 event is pending, and an acknowledge colliding with a new pulse on the same bit. A pulse timed against the sampling edges confirms the two-edge latency.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_STAT0  = 3'd0,
    ADDR_STAT1  = 3'd1,
    ADDR_MASK0  = 3'd2,
    ADDR_MASK1  = 3'd3,
    ADDR_EVMASK = 3'd4,
    ADDR_CFG    = 3'd5
  } reg_addr_e;

  // configuration register layout
  localparam int CFG_COMBINE_BIT = 0;
  localparam int CFG_FN_LSB      = 1;
  localparam int CFG_FN_W        = 2;
  localparam int CFG_USED_W      = CFG_FN_LSB + CFG_FN_W;

  typedef enum logic [CFG_FN_W-1:0] {
    PIN_FN_ALT_A  = 2'b00,
    PIN_FN_ALT_B  = 2'b01,
    PIN_FN_EVENT  = 2'b10,
    PIN_FN_ALT_A2 = 2'b11
  } pin_fn_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int           W       = 32,
  parameter logic [W-1:0] NM_BITS = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         stat_wr,
  input  logic         mask_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);

  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] ack_bits;

  assign ack_bits = stat_wr ? wdata : '0;

  // sticky status: set has priority over acknowledge
  always_ff @(posedge clk) begin
    if (rst) status_q <= RST_VAL;
    else     status_q <= (status_q & ~ack_bits) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(status_q & (mask_q | NM_BITS));

  // R2: every pulsed bit is visible in the next cycle
  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R10: collision of ack and set keeps the bit
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && |(wdata & set_i)) |=> ((status_q & $past(wdata & set_i)) == $past(wdata & set_i)));

  // R4: acknowledged bits without a new pulse are clear
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((status_q & $past(wdata & ~set_i)) == '0));

  // R4: bits written as zero keep their value or only gain pulses
  assert_zero_write_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((status_q & ~$past(wdata)) == (($past(status_q) | $past(set_i)) & ~$past(wdata))));

endmodule

// File: rtl/evt_merge.sv
module evt_merge
  import irq_event_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        level_i,
  input  logic [N-1:0]        enable_i,
  input  logic [CFG_FN_W-1:0] pin_fn_i,
  input  logic                alt_a_i,
  input  logic                alt_b_i,
  output logic                evt_n_o,
  output logic                pin_o
);

  logic any_active;
  logic evt_n_d;
  logic pin_d;
  logic evt_n_q;
  logic pin_q;

  assign any_active = |(level_i & enable_i);
  assign evt_n_d    = ~any_active;

  always_comb begin
    unique case (pin_fn_e'(pin_fn_i))
      PIN_FN_EVENT: pin_d = evt_n_d;
      PIN_FN_ALT_B: pin_d = alt_b_i;
      default:      pin_d = alt_a_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_n_q <= 1'b1;
      pin_q   <= 1'b1;
    end else begin
      evt_n_q <= evt_n_d;
      pin_q   <= pin_d;
    end
  end

  assign evt_n_o = evt_n_q;
  assign pin_o   = pin_q;

  // R7: an enabled active level pulls the output low one edge later
  assert_evt_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (|(level_i & enable_i)) |=> !evt_n_q);

  // R7: with no enabled level the output is high one edge later
  assert_evt_release_R7: assert property (@(posedge clk) disable iff (rst)
    ((level_i & enable_i) == '0) |=> evt_n_q);

  // R9: in event mode the shared pin equals the event output
  assert_pin_event_R9: assert property (@(posedge clk) disable iff (rst)
    (pin_fn_i == PIN_FN_EVENT) |=> (pin_q == evt_n_q));

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_event_pkg::*;
#(
  parameter int DW          = 32,
  parameter int EVN         = 16,
  parameter int RSTDONE_BIT = 16,
  parameter int ERR_BIT     = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [DW-1:0]         src_pulse0,
  input  logic [DW-1:0]         src_pulse1,
  input  logic [EVN-1:0]        evt_level,
  input  logic                  pin_alt_a,
  input  logic                  pin_alt_b,
  output logic                  irq0_n,
  output logic                  irq1_n,
  output logic                  evt_n,
  output logic                  pin_out
);

  localparam int           NLINES = 2;
  localparam logic [DW-1:0] RST0  = DW'(1) << RSTDONE_BIT;
  localparam logic [DW-1:0] NM0   = RST0 | (DW'(1) << ERR_BIT);

  logic [DW-1:0] set_vec [NLINES];
  logic [DW-1:0] stat_q  [NLINES];
  logic [DW-1:0] mask_q  [NLINES];
  logic          pend    [NLINES];

  logic                combine_q;
  logic [CFG_FN_W-1:0] pin_fn_q;
  logic [EVN-1:0]      evmask_q;
  logic                irq0_q;
  logic                irq1_q;

  assign set_vec[0] = src_pulse0;
  assign set_vec[1] = src_pulse1;

  // one status/mask bank per request line
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam logic [REG_ADDR_W-1:0] STAT_A = REG_ADDR_W'(ADDR_STAT0) + REG_ADDR_W'(g);
    localparam logic [REG_ADDR_W-1:0] MASK_A = REG_ADDR_W'(ADDR_MASK0) + REG_ADDR_W'(g);
    localparam logic [DW-1:0]         NM_G   = (g == 0) ? NM0  : '0;
    localparam logic [DW-1:0]         RST_G  = (g == 0) ? RST0 : '0;

    irq_status_bank #(
      .W      (DW),
      .NM_BITS(NM_G),
      .RST_VAL(RST_G)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_i   (set_vec[g]),
      .stat_wr (reg_wr && (reg_addr == STAT_A)),
      .mask_wr (reg_wr && (reg_addr == MASK_A)),
      .wdata   (reg_wdata),
      .status_o(stat_q[g]),
      .mask_o  (mask_q[g]),
      .pend_o  (pend[g])
    );
  end

  // configuration and event mask
  always_ff @(posedge clk) begin
    if (rst) begin
      combine_q <= 1'b0;
      pin_fn_q  <= PIN_FN_ALT_A;
      evmask_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CFG) begin
        combine_q <= reg_wdata[CFG_COMBINE_BIT];
        pin_fn_q  <= reg_wdata[CFG_FN_LSB +: CFG_FN_W];
      end
      if (reg_addr == ADDR_EVMASK) evmask_q <= reg_wdata[EVN-1:0];
    end
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        ADDR_STAT0:  reg_rdata <= stat_q[0];
        ADDR_STAT1:  reg_rdata <= stat_q[1];
        ADDR_MASK0:  reg_rdata <= mask_q[0];
        ADDR_MASK1:  reg_rdata <= mask_q[1];
        ADDR_EVMASK: reg_rdata <= {{(DW-EVN){1'b0}}, evmask_q};
        ADDR_CFG:    reg_rdata <= {{(DW-CFG_USED_W){1'b0}}, pin_fn_q, combine_q};
        default:     reg_rdata <= '0;
      endcase
    end
  end

  // registered request lines
  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_q <= 1'b1;
      irq1_q <= 1'b1;
    end else begin
      irq0_q <= ~pend[0];
      irq1_q <= ~(pend[1] | (combine_q & pend[0]));
    end
  end

  assign irq0_n = irq0_q;
  assign irq1_n = irq1_q;

  evt_merge #(.N(EVN)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .level_i (evt_level),
    .enable_i(evmask_q),
    .pin_fn_i(pin_fn_q),
    .alt_a_i (pin_alt_a),
    .alt_b_i (pin_alt_b),
    .evt_n_o (evt_n),
    .pin_o   (pin_out)
  );

  // R3: line 0 is low exactly one edge after a bank-0 pending condition
  assert_line0_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    pend[0] |=> !irq0_n);

  // R1: line 1 ignores bank 0 unless combined
  assert_line1_indep_R1: assert property (@(posedge clk) disable iff (rst)
    (!pend[1] && !combine_q) |=> irq1_n);

  // R6: combined mode mirrors a low line 0 onto line 1
  assert_combine_R6: assert property (@(posedge clk) disable iff (rst)
    (combine_q && pend[0]) |=> (!irq1_n && !irq0_n));

  // R5: the nonmaskable bits request without a mask bit
  assert_nonmask_R5: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q[0] & NM0)) |=> !irq0_n);

endmodule

// File: tb/irq_event_ctrl_test.sv
`timescale 1ns/1ps
module irq_event_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] src_pulse0 = '0;
  logic [31:0] src_pulse1 = '0;
  logic [15:0] evt_level = '0;
  logic        pin_alt_a = 1'b0;
  logic        pin_alt_b = 1'b0;
  logic        irq0_n, irq1_n, evt_n, pin_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  irq_event_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_pulse0(src_pulse0), .src_pulse1(src_pulse1),
    .evt_level(evt_level), .pin_alt_a(pin_alt_a), .pin_alt_b(pin_alt_b),
    .irq0_n(irq0_n), .irq1_n(irq1_n), .evt_n(evt_n), .pin_out(pin_out)
  );

  localparam logic [2:0] A_ST0 = 3'd0, A_ST1 = 3'd1, A_MK0 = 3'd2,
                         A_MK1 = 3'd3, A_EVM = 3'd4, A_CFG = 3'd5;
  localparam logic [31:0] B_RDONE = 32'h0001_0000;
  localparam logic [31:0] B_ERR   = 32'h0004_0000;

  // {evmask, level, pin_fn, alt_a, alt_b, exp_evt_n, exp_pin}
  localparam int NV = 8;
  localparam logic [37:0] EVEC [NV] = '{
    {16'h0000, 16'hffff, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h0001, 16'h0001, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h0001, 16'hfffe, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h8100, 16'h0100, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h8100, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'hffff, 16'h8000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'hffff, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h00f0, 16'h0010, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int line, input logic [31:0] bits);
    if (line == 0) src_pulse0 = bits; else src_pulse1 = bits;
    @(negedge clk);
    src_pulse0 = '0; src_pulse1 = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state (R11)
    evt_level = 16'hffff;
    repeat (3) @(negedge clk);
    chk("R11 irq0_n in reset", {31'b0, irq0_n}, 32'd1);
    chk("R11 irq1_n in reset", {31'b0, irq1_n}, 32'd1);
    chk("R11 evt_n in reset", {31'b0, evt_n}, 32'd1);
    chk("R11 pin_out in reset", {31'b0, pin_out}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset-done drives irq0_n", {31'b0, irq0_n}, 32'd0);
    chk("R1 irq1_n idle", {31'b0, irq1_n}, 32'd1);
    rd(A_ST0, rv); chk("R11 status0 after reset", rv, B_RDONE);
    rd(A_MK0, rv); chk("R11 mask0 after reset", rv, 32'd0);
    rd(A_CFG, rv); chk("R11 cfg after reset", rv, 32'd0);
    rd(A_EVM, rv); chk("R8 event mask after reset", rv, 32'd0);
    chk("R8 levels ignored after reset", {31'b0, evt_n}, 32'd1);
    evt_level = '0;

    // acknowledge reset-done (R4)
    wr(A_ST0, B_RDONE); settle();
    chk("R4 irq0_n after ack", {31'b0, irq0_n}, 32'd1);
    rd(A_ST0, rv); chk("R4 status0 cleared", rv, 32'd0);

    // masked event (R2, R3)
    pulse(0, 32'h0000_0008); settle();
    rd(A_ST0, rv); chk("R2 status set while masked", rv, 32'h0000_0008);
    chk("R3 masked bit keeps irq0_n high", {31'b0, irq0_n}, 32'd1);
    wr(A_MK0, 32'h0000_0028); settle();
    chk("R3 unmasking drives irq0_n low", {31'b0, irq0_n}, 32'd0);

    // two pending bits, acked one at a time (R4)
    pulse(0, 32'h0000_0020); settle();
    wr(A_ST0, 32'h0000_0008); settle();
    chk("R4 one enabled bit left keeps low", {31'b0, irq0_n}, 32'd0);
    rd(A_ST0, rv); chk("R4 zero-written bit kept", rv, 32'h0000_0020);
    wr(A_ST0, 32'h0000_0020); settle();
    chk("R4 all acked releases irq0_n", {31'b0, irq0_n}, 32'd1);

    // error bit is nonmaskable (R5)
    pulse(0, B_ERR); settle();
    chk("R5 error bit with mask 0", {31'b0, irq0_n}, 32'd0);
    wr(A_ST0, B_ERR); settle();
    chk("R5 error ack", {31'b0, irq0_n}, 32'd1);

    // bank 1 independence (R1)
    wr(A_MK1, 32'h0000_0080);
    pulse(1, 32'h0000_0080); settle();
    chk("R1 irq1_n low for bank 1", {31'b0, irq1_n}, 32'd0);
    chk("R1 irq0_n unaffected", {31'b0, irq0_n}, 32'd1);

    // set wins over simultaneous ack (R10)
    reg_wr = 1'b1; reg_addr = A_ST1; reg_wdata = 32'h0000_0080; src_pulse1 = 32'h0000_0080;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; src_pulse1 = '0;
    settle();
    rd(A_ST1, rv); chk("R10 set wins", rv, 32'h0000_0080);
    chk("R10 irq1_n still low", {31'b0, irq1_n}, 32'd0);
    wr(A_ST1, 32'h0000_0080); settle();
    chk("R4 irq1_n released", {31'b0, irq1_n}, 32'd1);

    // latency of request line (R12)
    pulse(1, 32'h0000_0080);
    chk("R12 irq1_n one edge after pulse", {31'b0, irq1_n}, 32'd1);
    @(negedge clk);
    chk("R12 irq1_n two edges after pulse", {31'b0, irq1_n}, 32'd0);
    wr(A_ST1, 32'h0000_0080); settle();

    // combine (R6)
    wr(A_CFG, 32'h0000_0001);
    pulse(0, 32'h0000_0008); settle();
    chk("R6 irq0_n low", {31'b0, irq0_n}, 32'd0);
    chk("R6 irq1_n mirrors bank 0", {31'b0, irq1_n}, 32'd1 ^ 32'd1);
    wr(A_CFG, 32'h0000_0000); settle();
    chk("R6 combine off frees irq1_n", {31'b0, irq1_n}, 32'd1);
    chk("R6 irq0_n still low", {31'b0, irq0_n}, 32'd0);
    wr(A_ST0, 32'h0000_0008); settle();

    // event table walk (R7, R9, R12)
    for (int i = 0; i < NV; i++) begin
      wr(A_EVM, {16'h0, EVEC[i][37:22]});
      wr(A_CFG, {29'b0, EVEC[i][5:4], 1'b0});
      evt_level = EVEC[i][21:6];
      pin_alt_a = EVEC[i][3];
      pin_alt_b = EVEC[i][2];
      @(negedge clk);
      chk($sformatf("R7 evt_n vector %0d", i), {31'b0, evt_n}, {31'b0, EVEC[i][1]});
      chk($sformatf("R9 pin_out vector %0d", i), {31'b0, pin_out}, {31'b0, EVEC[i][0]});
    end

    // unlatched tracking of a single source (R7)
    wr(A_EVM, 32'h0000_0004);
    wr(A_CFG, 32'h0000_0004);
    evt_level = 16'h0004; @(negedge clk);
    chk("R7 single source low", {31'b0, evt_n}, 32'd0);
    evt_level = 16'h0000; @(negedge clk);
    chk("R12 release after one edge", {31'b0, evt_n}, 32'd1);
    chk("R9 pin follows release", {31'b0, pin_out}, 32'd1);

    finish_run();
  end

endmodule